// File: doc/BRIEF.md
# SD Data Path Timeout Counter

This block watches the state code of an SD card data path controller and limits how long that controller may wait. A host writes a 32-bit timeout period, counted in card bus clock cycles. Two data path states are wait states: waiting for a read data block to start, and waiting for the card to release its busy signal. Each time the data path enters one of them, the block copies the period into a down-counter. The counter then steps down once for each card clock strobe, as long as the path stays in that wait state.

If the counter reaches zero while the path is still waiting, a sticky timeout flag is raised. It stays raised until the host pulses a clear input. When the path leaves the wait state before the counter runs out, counting stops and no timeout is raised. The period is read only at entry, so software programs it before it starts a transfer.

The block runs on the system clock. `card_tick` is a one-cycle enable that marks each card bus clock period. The asynchronous active-low reset is released through a two-stage synchronizer.

Top module: `sd_data_timeout`

## Requirements
- R1: After reset the period reads back as 32'h0000_0000 and `timeout_flag` is 0.
- R2: A cycle with `reg_wr` high stores `reg_wdata` as the period, and `reg_rdata` shows it after that clock edge.
- R3: `dp_state` is 3 bits wide. Code 3'd3 means waiting for read data and code 3'd5 means busy wait; every other code is a non-wait state. A cycle in which `dp_state` holds a wait code that differs from the previous cycle's code is an entry cycle. In an entry cycle the counter loads the period, and a `card_tick` in that cycle is not counted.
- R4: After an entry with period P, the flag rises at the clock edge that samples the max(P,1)-th counted `card_tick`, provided the path has stayed in the same wait state. So a period of 0 times out on the first tick after entry.
- R5: Once the path leaves the wait states, counting stops. Ticks outside wait states have no effect, and re-entering the wait state starts again from the full period.
- R6: A direct change from the read-wait code to the busy code counts as a new entry and reloads the full period.
- R7: The flag stays set until `status_clr` is high on a clock edge, which clears it. If a clear and an expiry fall on the same edge, the flag stays set.
- R8: Writing the period while a countdown is running does not change that countdown. The new value is used at the next entry.
- R9: An entry expires at most once. Further ticks in the same wait state after expiry do not set the flag again once it has been cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Period register write strobe |
| reg_wdata | input | 32 | Period write data |
| reg_rdata | output | 32 | Period register read data |
| card_tick | input | 1 | One-cycle strobe per card bus clock period |
| dp_state | input | 3 | Current data path state code |
| status_clr | input | 1 | Clears the timeout flag |
| timeout_flag | output | 1 | Sticky timeout status |

## Verification
Every result is due exactly one clock edge after the input that causes it. The period readback changes one edge after a write. The flag rises on the same edge that samples the deciding tick, and a clear takes effect on the edge where it is sampled. The bench drives all inputs 1 ns after a rising edge and samples outputs 1 ns after the next rising edge. It keeps its own count of the ticks it has issued since each entry cycle and compares the flag to max(P,1) on every cycle of the countdown. This is swept over periods 0 to 5, both wait codes and three tick spacings.

// File: rtl/sdt_pkg.sv
package sdt_pkg;
  localparam int unsigned SDT_PERIOD_W = 32;
  localparam int unsigned SDT_STATE_W  = 3;
  localparam logic [SDT_STATE_W-1:0] SDT_CODE_RDWAIT = 3'd3;
  localparam logic [SDT_STATE_W-1:0] SDT_CODE_BUSY   = 3'd5;

  typedef enum logic [1:0] {
    TRK_IDLE  = 2'd0,
    TRK_ARMED = 2'd1,
    TRK_SPENT = 2'd2
  } trk_phase_e;
endpackage

// File: rtl/sdt_period_reg.sv
module sdt_period_reg #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] period
);
  logic [WIDTH-1:0] period_d;
  logic [WIDTH-1:0] period_q;

  always_comb begin
    period_d = period_q;
    if (wr_en) period_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) period_q <= '0;
    else        period_q <= period_d;
  end

  assign period = period_q;

  // R2
  period_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (period == $past(wr_data)));
endmodule

// File: rtl/sdt_entry_detect.sv
module sdt_entry_detect #(
  parameter int unsigned            STATE_W   = 3,
  parameter logic [STATE_W-1:0]     CODE_RDW  = 3'd3,
  parameter logic [STATE_W-1:0]     CODE_BSY  = 3'd5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STATE_W-1:0] state,
  output logic               in_wait,
  output logic               entry
);
  logic [STATE_W-1:0] prev_q;
  logic [STATE_W-1:0] prev_d;
  logic               is_rdw;
  logic               is_bsy;

  always_comb begin
    is_rdw  = (state == CODE_RDW);
    is_bsy  = (state == CODE_BSY);
    in_wait = is_rdw | is_bsy;
    entry   = in_wait && (state != prev_q);
    prev_d  = state;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end
endmodule

// File: rtl/sdt_down_counter.sv
module sdt_down_counter
  import sdt_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             entry,
  input  logic             in_wait,
  input  logic             tick,
  input  logic [WIDTH-1:0] load_val,
  output logic             expire
);
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;
  trk_phase_e       ph_q;
  trk_phase_e       ph_d;

  always_comb begin
    cnt_d  = cnt_q;
    ph_d   = ph_q;
    expire = 1'b0;
    if (entry) begin
      cnt_d = load_val;
      ph_d  = TRK_ARMED;
    end else if (!in_wait) begin
      ph_d = TRK_IDLE;
    end else if ((ph_q == TRK_ARMED) && tick) begin
      if (cnt_q <= ONE) begin
        cnt_d  = '0;
        expire = 1'b1;
        ph_d   = TRK_SPENT;
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ph_q  <= TRK_IDLE;
    end else begin
      cnt_q <= cnt_d;
      ph_q  <= ph_d;
    end
  end

  // R3
  load_on_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry |=> (cnt_q == $past(load_val)));

  // R5
  hold_outside_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_wait |=> $stable(cnt_q));

  // R4
  never_count_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !entry |=> (cnt_q <= $past(cnt_q)));

  // R9
  single_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ph_q == TRK_SPENT) && !entry) |-> !expire);
endmodule

// File: rtl/sdt_sticky_flag.sv
module sdt_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  logic flag_q;
  logic flag_d;

  always_comb begin
    flag_d = flag_q;
    if (clr) flag_d = 1'b0;
    if (set) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;

  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag);

  // R7
  clear_works_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !flag);
endmodule

// File: rtl/sd_data_timeout.sv
module sd_data_timeout
  import sdt_pkg::*;
#(
  parameter int unsigned        PERIOD_W = SDT_PERIOD_W,
  parameter int unsigned        STATE_W  = SDT_STATE_W,
  parameter logic [STATE_W-1:0] CODE_RDW = SDT_CODE_RDWAIT,
  parameter logic [STATE_W-1:0] CODE_BSY = SDT_CODE_BUSY
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [PERIOD_W-1:0] reg_wdata,
  output logic [PERIOD_W-1:0] reg_rdata,
  input  logic                card_tick,
  input  logic [STATE_W-1:0]  dp_state,
  input  logic                status_clr,
  output logic                timeout_flag
);
  logic [1:0]          rst_pipe_q;
  logic                rst_sync_n;
  logic [PERIOD_W-1:0] period;
  logic                in_wait;
  logic                entry;
  logic                expire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  sdt_period_reg #(.WIDTH(PERIOD_W)) u_period (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (reg_wr),
    .wr_data (reg_wdata),
    .period  (period)
  );

  sdt_entry_detect #(
    .STATE_W  (STATE_W),
    .CODE_RDW (CODE_RDW),
    .CODE_BSY (CODE_BSY)
  ) u_entry (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .state   (dp_state),
    .in_wait (in_wait),
    .entry   (entry)
  );

  sdt_down_counter #(.WIDTH(PERIOD_W)) u_count (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .entry    (entry),
    .in_wait  (in_wait),
    .tick     (card_tick),
    .load_val (period),
    .expire   (expire)
  );

  sdt_sticky_flag u_flag (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .set   (expire),
    .clr   (status_clr),
    .flag  (timeout_flag)
  );

  assign reg_rdata = period;

  // R4
  rise_only_waiting_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(timeout_flag) |-> $past(in_wait));

  // R5
  idle_tick_harmless_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!in_wait && !timeout_flag) |=> !timeout_flag);
endmodule

// File: tb/tb_sd_data_timeout.sv
module tb_sd_data_timeout;
  localparam logic [2:0] RDW  = 3'd3;
  localparam logic [2:0] BSY  = 3'd5;
  localparam logic [2:0] IDLE = 3'd0;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        card_tick;
  logic [2:0]  dp_state;
  logic        status_clr;
  logic        timeout_flag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  sd_data_timeout dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .card_tick    (card_tick),
    .dp_state     (dp_state),
    .status_clr   (status_clr),
    .timeout_flag (timeout_flag)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic write_period(input logic [31:0] v);
    reg_wr = 1'b1; reg_wdata = v;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic clear_flag();
    status_clr = 1'b1;
    step();
    status_clr = 1'b0;
  endtask

  task automatic go_idle();
    dp_state = IDLE; card_tick = 1'b0;
    step();
  endtask

  // entry cycle always carries a tick, which must not be counted (R3)
  task automatic enter(input logic [2:0] code);
    dp_state = code; card_tick = 1'b1;
    step();
    card_tick = 1'b0;
  endtask

  task automatic run_case(input int p, input logic [2:0] code, input int stride);
    int need;
    int n;
    need = (p < 1) ? 1 : p;
    n = 0;
    go_idle();
    write_period(32'(p));
    clear_flag();
    chk(timeout_flag == 1'b0, "R7", 32'(timeout_flag), 0);
    enter(code);
    chk(timeout_flag == 1'b0, "R3", 32'(timeout_flag), 0);
    for (int i = 1; i <= need * stride + 2; i++) begin
      card_tick = ((i % stride) == 0);
      step();
      if (card_tick) n++;
      chk(timeout_flag == (n >= need), "R4", 32'(timeout_flag), 32'(n >= need));
    end
    card_tick = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_wdata = '0; card_tick = 1'b0;
    dp_state = IDLE; status_clr = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();

    // R1
    chk(reg_rdata == 32'h0, "R1", reg_rdata, 32'h0);
    chk(timeout_flag == 1'b0, "R1", 32'(timeout_flag), 0);

    // R2
    foreach (reg_wdata[b]) begin
      write_period(32'h1 << b);
      chk(reg_rdata == (32'h1 << b), "R2", reg_rdata, 32'h1 << b);
    end
    write_period(32'hDEAD_BEEF);
    chk(reg_rdata == 32'hDEAD_BEEF, "R2", reg_rdata, 32'hDEAD_BEEF);

    // R3 / R4 sweep
    for (int c = 0; c < 2; c++)
      for (int p = 0; p <= 5; p++)
        for (int s = 1; s <= 3; s++)
          run_case(p, (c == 0) ? RDW : BSY, s);

    // R5: leave early, idle ticks, re-entry from full period
    go_idle(); write_period(32'd4); clear_flag();
    enter(RDW);
    for (int i = 0; i < 3; i++) begin card_tick = 1'b1; step(); end
    dp_state = IDLE;
    for (int i = 0; i < 6; i++) begin
      card_tick = 1'b1; step();
      chk(timeout_flag == 1'b0, "R5", 32'(timeout_flag), 0);
    end
    card_tick = 1'b0;
    enter(RDW);
    for (int i = 1; i <= 4; i++) begin
      card_tick = 1'b1; step();
      chk(timeout_flag == (i == 4), "R5", 32'(timeout_flag), 32'(i == 4));
    end
    card_tick = 1'b0;

    // R6: read-wait straight into busy reloads
    go_idle(); write_period(32'd3); clear_flag();
    enter(RDW);
    for (int i = 0; i < 2; i++) begin card_tick = 1'b1; step(); end
    enter(BSY);
    for (int i = 1; i <= 3; i++) begin
      card_tick = 1'b1; step();
      chk(timeout_flag == (i == 3), "R6", 32'(timeout_flag), 32'(i == 3));
    end
    card_tick = 1'b0;

    // R7: sticky after leaving, clear, clear colliding with expiry
    go_idle();
    for (int i = 0; i < 3; i++) begin
      step();
      chk(timeout_flag == 1'b1, "R7", 32'(timeout_flag), 1);
    end
    clear_flag();
    chk(timeout_flag == 1'b0, "R7", 32'(timeout_flag), 0);
    write_period(32'd2);
    enter(BSY);
    card_tick = 1'b1; step();
    card_tick = 1'b1; status_clr = 1'b1; step();
    status_clr = 1'b0; card_tick = 1'b0;
    chk(timeout_flag == 1'b1, "R7", 32'(timeout_flag), 1);

    // R9: after expiry and clear, more ticks in same wait do nothing
    clear_flag();
    for (int i = 0; i < 8; i++) begin
      card_tick = 1'b1; step();
      chk(timeout_flag == 1'b0, "R9", 32'(timeout_flag), 0);
    end
    card_tick = 1'b0;

    // R8: period written mid-countdown is deferred
    go_idle(); write_period(32'd5); clear_flag();
    enter(RDW);
    write_period(32'd1);
    for (int i = 1; i <= 5; i++) begin
      card_tick = 1'b1; step();
      chk(timeout_flag == (i == 5), "R8", 32'(timeout_flag), 32'(i == 5));
    end
    card_tick = 1'b0;
    go_idle(); clear_flag();
    enter(RDW);
    card_tick = 1'b1; step(); card_tick = 1'b0;
    chk(timeout_flag == 1'b1, "R8", 32'(timeout_flag), 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule